// File: doc/BRIEF.md
# Time-Multiplexed Multi-Write Register File

This block gives a base-rate pipeline a register file with several write ports and several read ports. Only one two-port storage array sits behind them. The array runs on a fast clock. A one-cycle strobe, `base_stb`, marks the start of each base cycle. The array serves the requests of one base cycle one after another, spread over the fast cycles that follow the strobe.

On the strobe edge the block captures every write request and every read address. A subcycle sequencer then steers requests onto the two array ports:

- Reads go in the early subcycles, two per subcycle.
- Writes go in the later subcycles, two per subcycle.
- The lower-numbered request of each pair uses port A, and the higher-numbered one uses port B.

Because the reads come first, each read returns the value held before that base cycle's writes. This gives write-after-read behaviour inside one base cycle. Read results are collected in a staging register. They are handed to the output register on the next strobe, so the pipeline sees read data one base cycle after it asked.

The fast clock and the base clock are modelled as one clock plus a strobe. The strobe must be spaced at least one full schedule apart. The schedule is ceil(NUM_RD/2) read subcycles plus ceil(NUM_WR/2) write subcycles, which is 4 clocks for the defaults. A wider spacing leaves idle subcycles.

Top module: `mwrf_top`

## Requirements
- R1: After reset, `rd_data` is all zeros and every storage entry reads as zero.
- R2: Write enables, write addresses, write data and read addresses are sampled only on a clock edge where `base_stb` is 1. Values on these inputs at any other edge have no effect.
- R3: After a strobe edge, the subcycle index is 0. It then advances by one per clock through ceil(NUM_RD/2)+ceil(NUM_WR/2) subcycles. Read subcycle s serves read ports 2s and 2s+1. Write subcycle w serves write ports 2w and 2w+1.
- R4: A read returns the storage contents from before every write captured on the same strobe, even when it targets an address written in that base cycle.
- R5: Writes captured on one strobe are visible to reads captured on the next strobe.
- R6: When several enabled write ports target the same address in one base cycle, the highest-numbered one determines the stored value. Within one subcycle, port B wins over port A.
- R7: A write port whose enable bit (`wr_en[p]`) is 0 leaves storage unchanged, whatever its address and data.
- R8: `rd_data` changes only on strobe edges. After strobe n+1 it carries the results of the reads captured on strobe n. Read port r occupies bits [r*DATA_W +: DATA_W].
- R9: When strobes are spaced further apart than the schedule, the extra subcycles perform no storage access and results are unchanged.
- R10: Read ports that give the same address in one base cycle all return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_stb | input | 1 | Marks the first fast cycle of a base cycle; inputs are captured on this edge |
| wr_en | input | NUM_WR | Per-port write enable; bit p belongs to write port p |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses; port p at [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data; port p at [p*DATA_W +: DATA_W] |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses; port r at [r*ADDR_W +: ADDR_W] |
| rd_data | output | NUM_RD*DATA_W | Read results from the previous base cycle; port r at [r*DATA_W +: DATA_W] |

## Verification
A sequencer that is off by one subcycle shows up at the very next strobe. One of two things happens: a read misses its staging slot, or a read lands after a write. The misplaced read is then visible on `rd_data` as a post-write or stale value one base cycle after the request. A fault in the write steering or in port priority corrupts storage silently. It shows up as soon as a later base cycle reads that address, which is within a few base cycles under dense random traffic over a 16-entry array. Garbage is driven on the inputs between strobes, so a capture that leaks outside the strobe edge corrupts the next result directly.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;
    function automatic int half_up(input int n);
        return (n + 1) / 2;
    endfunction

    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/mwrf_seq.sv
module mwrf_seq #(
    parameter int SUB_N = 4,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_stb,
    output logic [SUB_W-1:0] sub_idx,
    output logic             active
);
    localparam logic [SUB_W-1:0] LAST = SUB_W'(SUB_N - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic             act;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (base_stb) begin
            s_d.sub = '0;
            s_d.act = 1'b1;
        end else if (s_q.act) begin
            if (s_q.sub == LAST) begin
                s_d.act = 1'b0;
            end else begin
                s_d.sub = s_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sub_idx = s_q.sub;
    assign active  = s_q.act;

    a_r3_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        base_stb |=> (active && sub_idx == '0));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !base_stb && sub_idx != LAST) |=> (active && sub_idx == $past(sub_idx) + 1'b1));

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !base_stb && sub_idx == LAST) |=> !active);

    a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> sub_idx <= LAST);
endmodule

// File: rtl/mwrf_steer.sv
module mwrf_steer #(
    parameter int NUM_WR = 4,
    parameter int NUM_RD = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int SUB_W  = 2,
    parameter int RSEL_W = 2
) (
    input  logic [SUB_W-1:0]         sub_idx,
    input  logic                     active,
    input  logic [NUM_WR-1:0]        req_wen,
    input  logic [NUM_WR*ADDR_W-1:0] req_waddr,
    input  logic [NUM_WR*DATA_W-1:0] req_wdata,
    input  logic [NUM_RD*ADDR_W-1:0] req_raddr,
    output logic                     a_re,
    output logic [RSEL_W-1:0]        a_sel,
    output logic                     a_we,
    output logic [ADDR_W-1:0]        a_addr,
    output logic [DATA_W-1:0]        a_wdata,
    output logic                     b_re,
    output logic [RSEL_W-1:0]        b_sel,
    output logic                     b_we,
    output logic [ADDR_W-1:0]        b_addr,
    output logic [DATA_W-1:0]        b_wdata
);
    localparam int RD_SLOTS = mwrf_pkg::half_up(NUM_RD);
    localparam int WR_SLOTS = mwrf_pkg::half_up(NUM_WR);

    always_comb begin
        a_re = 1'b0; a_sel = '0; a_we = 1'b0; a_addr = '0; a_wdata = '0;
        b_re = 1'b0; b_sel = '0; b_we = 1'b0; b_addr = '0; b_wdata = '0;
        for (int s = 0; s < RD_SLOTS; s++) begin
            if (active && sub_idx == SUB_W'(s)) begin
                a_re   = 1'b1;
                a_sel  = RSEL_W'(2 * s);
                a_addr = req_raddr[(2 * s) * ADDR_W +: ADDR_W];
                if (2 * s + 1 < NUM_RD) begin
                    b_re   = 1'b1;
                    b_sel  = RSEL_W'(2 * s + 1);
                    b_addr = req_raddr[((2 * s + 1 < NUM_RD) ? 2 * s + 1 : 2 * s) * ADDR_W +: ADDR_W];
                end
            end
        end
        for (int w = 0; w < WR_SLOTS; w++) begin
            if (active && sub_idx == SUB_W'(RD_SLOTS + w)) begin
                a_we    = req_wen[2 * w];
                a_addr  = req_waddr[(2 * w) * ADDR_W +: ADDR_W];
                a_wdata = req_wdata[(2 * w) * DATA_W +: DATA_W];
                if (2 * w + 1 < NUM_WR) begin
                    b_we    = req_wen[(2 * w + 1 < NUM_WR) ? 2 * w + 1 : 2 * w];
                    b_addr  = req_waddr[((2 * w + 1 < NUM_WR) ? 2 * w + 1 : 2 * w) * ADDR_W +: ADDR_W];
                    b_wdata = req_wdata[((2 * w + 1 < NUM_WR) ? 2 * w + 1 : 2 * w) * DATA_W +: DATA_W];
                end
            end
        end
    end
endmodule

// File: rtl/mwrf_dpram.sv
module mwrf_dpram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (a_we) mem_d[a_addr] = a_wdata;
        if (b_we) mem_d[b_addr] = b_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign a_rdata = mem_q[a_addr];
    assign b_rdata = mem_q[b_addr];

    a_r6_port_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |=> mem_q[$past(b_addr)] == $past(b_wdata));

    a_r6_port_a_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && !(b_we && b_addr == a_addr)) |=> mem_q[$past(a_addr)] == $past(a_wdata));
endmodule

// File: rtl/mwrf_top.sv
module mwrf_top #(
    parameter int NUM_WR = 4,
    parameter int NUM_RD = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     base_stb,
    input  logic [NUM_WR-1:0]        wr_en,
    input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WR*DATA_W-1:0] wr_data,
    input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
    output logic [NUM_RD*DATA_W-1:0] rd_data
);
    localparam int SUB_N  = mwrf_pkg::half_up(NUM_RD) + mwrf_pkg::half_up(NUM_WR);
    localparam int SUB_W  = mwrf_pkg::width_of(SUB_N);
    localparam int RSEL_W = mwrf_pkg::width_of(NUM_RD);

    typedef struct packed {
        logic [NUM_WR-1:0]        wen;
        logic [NUM_WR*ADDR_W-1:0] waddr;
        logic [NUM_WR*DATA_W-1:0] wdata;
        logic [NUM_RD*ADDR_W-1:0] raddr;
        logic [NUM_RD*DATA_W-1:0] stage;
        logic [NUM_RD*DATA_W-1:0] rout;
    } top_t;

    top_t st_d, st_q;

    logic [SUB_W-1:0]  sub_idx;
    logic              active;
    logic              a_re, a_we, b_re, b_we;
    logic [RSEL_W-1:0] a_sel, b_sel;
    logic [ADDR_W-1:0] a_addr, b_addr;
    logic [DATA_W-1:0] a_wdata, b_wdata, a_rdata, b_rdata;

    mwrf_seq #(.SUB_N(SUB_N), .SUB_W(SUB_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .base_stb(base_stb),
        .sub_idx(sub_idx), .active(active)
    );

    mwrf_steer #(
        .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .SUB_W(SUB_W), .RSEL_W(RSEL_W)
    ) u_steer (
        .sub_idx(sub_idx), .active(active),
        .req_wen(st_q.wen), .req_waddr(st_q.waddr),
        .req_wdata(st_q.wdata), .req_raddr(st_q.raddr),
        .a_re(a_re), .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_re(b_re), .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata)
    );

    mwrf_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (base_stb) begin
            st_d.wen   = wr_en;
            st_d.waddr = wr_addr;
            st_d.wdata = wr_data;
            st_d.raddr = rd_addr;
            st_d.rout  = st_q.stage;
        end
        for (int r = 0; r < NUM_RD; r++) begin
            if (a_re && a_sel == RSEL_W'(r)) st_d.stage[r * DATA_W +: DATA_W] = a_rdata;
            if (b_re && b_sel == RSEL_W'(r)) st_d.stage[r * DATA_W +: DATA_W] = b_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rout;

    // R8: output register only moves on a strobe edge
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !base_stb |=> $stable(rd_data));

    // R2: captured requests are untouched between strobes
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !base_stb |=> ($stable(st_q.wen) && $stable(st_q.waddr) && $stable(st_q.wdata) && $stable(st_q.raddr)));

    // R4: once a write subcycle has run, no read follows before the next strobe
    a_r4_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_we || b_we) && !base_stb) |=> !(a_re || b_re));

    // R9: idle subcycles touch no storage port
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(a_we || b_we || a_re || b_re));
endmodule

// File: tb/mwrf_top_bench.sv
module mwrf_top_bench;
    localparam int NW  = 4;
    localparam int NR  = 3;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int SUB = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              base_stb = 1'b0;
    logic [NW-1:0]     wr_en = '0;
    logic [NW*AW-1:0]  wr_addr = '0;
    logic [NW*DW-1:0]  wr_data = '0;
    logic [NR*AW-1:0]  rd_addr = '0;
    logic [NR*DW-1:0]  rd_data;

    mwrf_top #(.NUM_WR(NW), .NUM_RD(NR), .ADDR_W(AW), .DATA_W(DW)) u_mwrf_top (
        .clk(clk), .rst_n(rst_n), .base_stb(base_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [DW-1:0] model [1 << AW];
    logic          q_en   [NW];
    logic [AW-1:0] q_wa   [NW];
    logic [DW-1:0] q_wd   [NW];
    logic [AW-1:0] q_ra   [NR];
    logic [DW-1:0] exp_out  [NR];
    logic [DW-1:0] next_exp [NR];
    string         cur_tag = "R1";
    string         next_tag = "R1";

    task automatic check(input string tag, input int port, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s port %0d actual %h expected %h", tag, port, act, exp);
        end
    endtask

    task automatic compare_out();
        for (int r = 0; r < NR; r++) check(cur_tag, r, rd_data[r*DW +: DW], exp_out[r]);
    endtask

    task automatic scramble();
        wr_en   = NW'($urandom);
        wr_addr = {$urandom, $urandom};
        wr_data = {$urandom, $urandom};
        rd_addr = NR*AW'($urandom);
    endtask

    task automatic run_cycle(input int gap, input string tag);
        logic [DW-1:0] nexp [NR];
        @(negedge clk);
        base_stb = 1'b1;
        for (int p = 0; p < NW; p++) begin
            wr_en[p] = q_en[p];
            wr_addr[p*AW +: AW] = q_wa[p];
            wr_data[p*DW +: DW] = q_wd[p];
        end
        for (int r = 0; r < NR; r++) begin
            rd_addr[r*AW +: AW] = q_ra[r];
            nexp[r] = model[q_ra[r]];
        end
        for (int p = 0; p < NW; p++) if (q_en[p]) model[q_wa[p]] = q_wd[p];
        @(posedge clk);
        #1;
        exp_out  = next_exp;
        next_exp = nexp;
        cur_tag  = next_tag;
        next_tag = tag;
        @(negedge clk);
        base_stb = 1'b0;
        scramble();
        compare_out();
        for (int k = 0; k < SUB - 2 + gap; k++) begin
            @(negedge clk);
            scramble();
            compare_out();
        end
    endtask

    task automatic rand_req();
        for (int p = 0; p < NW; p++) begin
            q_en[p] = 1'($urandom);
            q_wa[p] = AW'($urandom);
            q_wd[p] = DW'($urandom);
        end
        for (int r = 0; r < NR; r++) q_ra[r] = AW'($urandom);
    endtask

    task automatic no_write();
        for (int p = 0; p < NW; p++) q_en[p] = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        for (int r = 0; r < NR; r++) begin exp_out[r] = '0; next_exp[r] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on the output
        for (int r = 0; r < NR; r++) check("R1", r, rd_data[r*DW +: DW], '0);

        // R1: untouched storage reads as zero
        no_write();
        for (int r = 0; r < NR; r++) q_ra[r] = AW'(r * 5 + 1);
        run_cycle(0, "R1");

        // R4: write and read the same address in one base cycle -> old value
        no_write();
        q_en[0] = 1'b1; q_wa[0] = 4'd5; q_wd[0] = 16'hA5A5;
        for (int r = 0; r < NR; r++) q_ra[r] = 4'd5;
        run_cycle(0, "R4");

        // R5, R10: next base cycle sees the write on every read port
        no_write();
        for (int r = 0; r < NR; r++) q_ra[r] = 4'd5;
        run_cycle(0, "R5");
        no_write();
        for (int r = 0; r < NR; r++) q_ra[r] = 4'd5;
        run_cycle(0, "R10");

        // R6: all ports write address 3
        for (int p = 0; p < NW; p++) begin q_en[p] = 1'b1; q_wa[p] = 4'd3; q_wd[p] = DW'(p + 1); end
        for (int r = 0; r < NR; r++) q_ra[r] = 4'd9;
        run_cycle(0, "R6");
        no_write();
        for (int r = 0; r < NR; r++) q_ra[r] = 4'd3;
        run_cycle(0, "R6");

        // R7: disabled highest port must not land
        for (int p = 0; p < NW; p++) begin q_en[p] = (p != NW - 1); q_wa[p] = 4'd3; q_wd[p] = DW'(16'h0100 + p); end
        q_wd[NW-1] = 16'hDEAD;
        run_cycle(0, "R7");
        no_write();
        for (int r = 0; r < NR; r++) q_ra[r] = 4'd3;
        run_cycle(0, "R7");
        no_write();
        run_cycle(0, "R7");

        // R3: back-to-back strobes at exactly the schedule length
        for (int i = 0; i < 100; i++) begin rand_req(); run_cycle(0, "R3"); end
        // R9: strobes spaced wider than the schedule
        for (int i = 0; i < 100; i++) begin rand_req(); run_cycle(1 + (i % 3), "R9"); end
        // R8: output hold across long gaps
        for (int i = 0; i < 60; i++) begin rand_req(); run_cycle(5, "R8"); end
        // R2: dense random traffic with garbage between strobes
        for (int i = 0; i < 400; i++) begin rand_req(); run_cycle(0, "R2"); end
        no_write();
        run_cycle(0, "R2");
        run_cycle(0, "R2");
        finish_run();
    end
endmodule